// File: doc/BRIEF.md
# Tagged Read Response Width Converter

This block sits between an upstream read-response stream of fixed width and a client that expects words of a different width. Each incoming beat carries a tag next to its data. Only the data goes through the width conversion. The tag is kept in a side register and is attached again to the converted word on the way out. Both sides use valid/ready handshakes.

When the client word is wider than a beat, the block gathers ceil(OUT_W/IN_W) beats into one word. When the client word is narrower than or equal to a beat, each beat becomes exactly one client word. A completed word stays in the output register until the client takes it. A new beat is accepted in the same cycle that the client consumes the pending word.

Top module: `tag_read_gearbox`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high. The beat counter restarts at the first beat of a group.
- R2: When OUT_W > IN_W, BEATS = ceil(OUT_W/IN_W) accepted beats form one word. The first beat fills bits [IN_W-1:0], and each later beat fills the next IN_W bits. `out_valid` rises on the clock edge that accepts the last beat of the group, and on no earlier beat.
- R3: When OUT_W <= IN_W, every accepted beat yields one output word equal to bits [OUT_W-1:0] of that beat's data. The higher data bits are discarded.
- R4: The output tag is the tag of the first beat of its group. Tags on the later beats of the same group have no effect on the output.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_tag` hold their values.
- R6: `in_ready` is low while a completed word is pending and `out_ready` is low. `in_ready` is high when no word is pending or when the pending word is consumed in that cycle.
- R7: When OUT_W is not a multiple of IN_W, the bits of the last beat above the output width are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_tag | input | TAG_W | Tag of the upstream beat |
| in_data | input | IN_W | Data of the upstream beat |
| out_valid | output | 1 | Converted word valid |
| out_ready | input | 1 | Client takes the word |
| out_tag | output | TAG_W | Tag attached to the word |
| out_data | output | OUT_W | Converted data word |

## Verification
The assertions assume that upstream beats arrive in whole groups and that the client obeys the handshake. They do not assume that the tags within a group agree, because the tag property only compares the output against the first beat of each group. The stimulus drives complete groups and gives the later beats deliberately different tags, so that R4 is exercised rather than assumed. The client's ready is varied between always-on and pseudo-random stalls. One instance covers the widening mode, where 80 bits are built from three 32-bit beats, and a second instance covers the narrowing mode, where 32 bits are reduced to 12.

// File: rtl/tag_read_gearbox.sv
module tag_read_gearbox #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 80,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [TAG_W-1:0] out_tag,
  output logic [OUT_W-1:0] out_data
);
  localparam int BEATS = (OUT_W + IN_W - 1) / IN_W;
  localparam int CNT_W = BEATS > 1 ? $clog2(BEATS) : 1;
  localparam int ACC_W = BEATS * IN_W;

  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cnt;
  logic [TAG_W-1:0] tag_q;
  logic             vld;

  wire take = in_valid && in_ready;
  wire last = (cnt == CNT_W'(BEATS - 1));

  assign in_ready  = !vld || out_ready;
  assign out_valid = vld;
  assign out_tag   = tag_q;
  assign out_data  = acc[OUT_W-1:0];

  generate
    if (ACC_W > OUT_W) begin : g_drop
      wire unused_hi = ^acc[ACC_W-1:OUT_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (take) begin
      acc[cnt*IN_W +: IN_W] <= in_data;
      if (cnt == '0) tag_q <= in_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      vld <= 1'b0;
    end else begin
      if (take) cnt <= last ? '0 : cnt + 1'b1;
      if (take && last) vld <= 1'b1;
      else if (out_ready) vld <= 1'b0;
    end
  end
endmodule

// File: rtl/tag_read_gearbox_chk.sv
module tag_read_gearbox_chk #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 80,
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [TAG_W-1:0] in_tag,
  input logic             out_valid,
  input logic             out_ready,
  input logic [TAG_W-1:0] out_tag,
  input logic [OUT_W-1:0] out_data
);
  localparam int BEATS = (OUT_W + IN_W - 1) / IN_W;
  localparam int CNT_W = BEATS > 1 ? $clog2(BEATS) : 1;

  logic [CNT_W-1:0] beat_cnt;
  logic [TAG_W-1:0] held_tag;
  wire acc_beat  = in_valid && in_ready;
  wire grp_end   = acc_beat && (beat_cnt == CNT_W'(BEATS - 1));
  wire [TAG_W-1:0] grp_tag = (beat_cnt == '0) ? in_tag : held_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_cnt <= '0;
      held_tag <= '0;
    end else if (acc_beat) begin
      beat_cnt <= grp_end ? '0 : beat_cnt + 1'b1;
      if (beat_cnt == '0) held_tag <= in_tag;
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_tag));

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(grp_end));

  p_mid_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_beat && !grp_end && !out_valid |=> !out_valid);

  p_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grp_end |=> out_valid && out_tag == $past(grp_tag));
endmodule

bind tag_read_gearbox tag_read_gearbox_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag),
  .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag), .out_data(out_data)
);

// File: tb/tag_read_gearbox_tb.sv
module tag_read_gearbox_tb;
  localparam int TW = 6;
  localparam int IW = 32;
  localparam int WOW = 80;
  localparam int NOW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int rdy_mode = 0;

  logic          w_iv = 1'b0, w_or = 1'b1, w_ir, w_ov;
  logic [TW-1:0] w_it = '0, w_ot;
  logic [IW-1:0] w_id = '0;
  logic [WOW-1:0] w_od;

  logic          n_iv = 1'b0, n_or = 1'b1, n_ir, n_ov;
  logic [TW-1:0] n_it = '0, n_ot;
  logic [IW-1:0] n_id = '0;
  logic [NOW-1:0] n_od;

  tag_read_gearbox #(.IN_W(IW), .OUT_W(WOW), .TAG_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(w_iv), .in_ready(w_ir), .in_tag(w_it), .in_data(w_id),
    .out_valid(w_ov), .out_ready(w_or), .out_tag(w_ot), .out_data(w_od));

  tag_read_gearbox #(.IN_W(IW), .OUT_W(NOW), .TAG_W(TW)) u_dut_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(n_iv), .in_ready(n_ir), .in_tag(n_it), .in_data(n_id),
    .out_valid(n_ov), .out_ready(n_or), .out_tag(n_ot), .out_data(n_od));

  logic [TW+WOW-1:0] w_q[$];
  logic [TW+NOW-1:0] n_q[$];

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w_beat(input logic [TW-1:0] t, input logic [IW-1:0] d);
    @(negedge clk);
    w_iv = 1'b1; w_it = t; w_id = d;
    #2;
    while (!w_ir) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    w_iv = 1'b0;
  endtask

  task automatic w_group(input logic [TW-1:0] t, input logic [IW-1:0] a, input logic [IW-1:0] b, input logic [IW-1:0] c);
    logic [3*IW-1:0] cat;
    cat = {c, b, a};
    w_q.push_back({t, cat[WOW-1:0]});   // R2 R7 expectation
    w_beat(t, a);
    w_beat(t ^ 6'h2a, b);               // R4: later tags differ
    w_beat(t ^ 6'h15, c);
  endtask

  task automatic n_beat(input logic [TW-1:0] t, input logic [IW-1:0] d);
    n_q.push_back({t, d[NOW-1:0]});     // R3 expectation
    @(negedge clk);
    n_iv = 1'b1; n_it = t; n_id = d;
    #2;
    while (!n_ir) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    n_iv = 1'b0;
  endtask

  logic [TW+WOW-1:0] w_last;
  logic              w_held = 1'b0;
  always @(negedge clk) begin
    w_or = (rdy_mode == 0) ? 1'b1 : 1'($urandom_range(0, 2) == 0);
    #1;
    if (rst_n) begin
      if (w_held) check({w_ot, w_od} == w_last && w_ov, "R5", {w_ot, w_od}, w_last);
      if (w_ov && !w_or) check(!w_ir, "R6", w_ir, 0);
      if (w_ov && w_or) begin
        logic [TW+WOW-1:0] e;
        check(w_ir, "R6", w_ir, 1);
        if (w_q.size() == 0) check(0, "R2", {w_ot, w_od}, 0);
        else begin
          e = w_q.pop_front();
          check({w_ot, w_od} == e, "R2/R4", {w_ot, w_od}, e);
        end
      end
      w_held = w_ov && !w_or;
      w_last = {w_ot, w_od};
    end
  end

  logic [TW+NOW-1:0] n_last;
  logic              n_held = 1'b0;
  always @(negedge clk) begin
    n_or = (rdy_mode == 0) ? 1'b1 : 1'($urandom_range(0, 2) == 0);
    #1;
    if (rst_n) begin
      if (n_held) check({n_ot, n_od} == n_last && n_ov, "R5", {n_ot, n_od}, n_last);
      if (n_ov && !n_or) check(!n_ir, "R6", n_ir, 0);
      if (n_ov && n_or) begin
        logic [TW+NOW-1:0] e;
        if (n_q.size() == 0) check(0, "R3", {n_ot, n_od}, 0);
        else begin
          e = n_q.pop_front();
          check({n_ot, n_od} == e, "R3", {n_ot, n_od}, e);
        end
      end
      n_held = n_ov && !n_or;
      n_last = {n_ot, n_od};
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!w_ov && w_ir, "R1", {w_ov, w_ir}, 2'b01);
    check(!n_ov && n_ir, "R1", {n_ov, n_ir}, 2'b01);
    // R2: no output after only two beats of a group
    w_q.push_back({6'h11, 16'hbeef, 32'h0123_4567, 32'h89ab_cdef});
    w_beat(6'h11, 32'h89ab_cdef);
    w_beat(6'h3f, 32'h0123_4567);
    @(negedge clk); #2;
    check(!w_ov, "R2", w_ov, 0);
    w_beat(6'h00, 32'hffff_beef);      // R7: upper 16 bits dropped
    for (int m = 0; m < 2; m++) begin
      rdy_mode = m;
      for (int i = 0; i < 12; i++)
        w_group(TW'($urandom), $urandom, $urandom, $urandom);
      for (int i = 0; i < 16; i++)
        n_beat(TW'($urandom), $urandom);
    end
    n_beat(6'h05, 32'hffff_f000);       // R3: low 12 bits kept
    n_beat(6'h06, 32'h0000_0abc);
    rdy_mode = 0;
    repeat (20) @(posedge clk);
    check(w_q.size() == 0, "R2", w_q.size(), 0);
    check(n_q.size() == 0, "R3", n_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule